// File: doc/BRIEF.md
# Zero-Suppressing Hit-Word Readout Controller

This block reads a fixed number of serial chains of latched wire bits, one chain after another, and turns them into compact data words. For the chain being read it produces a burst of readout clock pulses; the front end presents one bit per pulse. Every group holds eight wire bits followed by one parity bit. A group in which no wire is hit is discarded. A group with at least one hit becomes a 16-bit word that carries the wire pattern, the global block address of the group and a flag for a parity mismatch. The readout clock stays low whenever no readout is running, so no clock travels toward the detector between events.

A single-cycle read command starts a readout. A busy output stays high until the last group of the last chain has been handled. Each kept group also fires a fixed-width trigger pulse, which a downstream scaler can count. Words wait in a small FIFO and leave through a valid/ready handshake. If the FIFO fills, the controller pauses at a group boundary with the readout clock held low. A fast clear aborts the readout, empties the FIFO and returns the controller to idle.

With the default parameters (4 chains, 32 groups per chain, 2 cycles per clock phase) and an 80 MHz system clock, the readout clock runs at 20 MHz. A 256-wire chain then takes 1184 cycles, which is 14.8 µs.

Top module: `hwr_readout`

## Requirements
- R1: While busy is low, every bit of ro_clk is low. At most one bit of ro_clk is high at any time, and it belongs to the chain being read.
- R2: Chains are read in order 0 up to NUM_STREAMS-1. Each chain receives exactly GROUPS_PER_STREAM×(GROUP_WIDTH+1) readout clock pulses (288 at default). The high and low phases of each pulse last HALF_PERIOD cycles each.
- R3: Within a group the front end sends wire 0 first, which lands in word bit 0, then wires 1 to 7, then the parity bit. The controller samples ro_data in the last cycle of each high phase, so the front end may change the data after each falling edge.
- R4: The word layout is: bits [7:0] hold the wire pattern, bits [14:8] hold the block address (chain×32 + group index), and bit 15 is the parity error flag. Parity is odd: the flag is 0 when the nine received bits contain an odd number of ones, and 1 otherwise.
- R5: A group whose eight wire bits are all zero produces no word and no trigger pulse, even when its parity bit is wrong.
- R6: Words leave in ascending block address order.
- R7: Each kept group produces exactly one trigger pulse of TRIG_CYCLES cycles (4 at default). TRIG_CYCLES must be shorter than one group slot.
- R8: busy rises on the clock edge that accepts read_start. Without a stall it stays high for exactly NUM_STREAMS×GROUPS_PER_STREAM×(2×HALF_PERIOD×(GROUP_WIDTH+1)+1) cycles, which is 4736 at default. A read_start that arrives while busy is high is ignored.
- R9: When the FIFO is full and a kept group is ready to be stored, the readout pauses with ro_clk low until space frees up. No word is lost or duplicated.
- R10: A fast_clear drives busy, ro_clk, word_valid and trig_out low on the next cycle and discards the stored words. The next read command then reads the chains correctly from the start.
- R11: After reset, busy, trig_out, word_valid and all ro_clk bits are low.
- R12: While word_valid is high and word_ready is low, word_valid stays high and word_data stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| read_start | input | 1 | Single-cycle command that starts a readout |
| fast_clear | input | 1 | Aborts the readout and empties the FIFO |
| ro_clk | output | NUM_STREAMS | Gated readout clock, one bit per chain |
| ro_data | input | NUM_STREAMS | Serial data, one bit per chain |
| busy | output | 1 | High while a readout is in progress |
| trig_out | output | 1 | One fixed-width pulse per kept group |
| word_valid | output | 1 | A word is available at word_data |
| word_ready | input | 1 | The consumer accepts the word |
| word_data | output | WORD_W | Parity flag, block address and wire pattern |

## Verification
The bench goes after the following corner cases:
- Hits at the first and last address (0 and 127). A wrong address computation or a wrong chain order would misplace these words.
- A group with an empty pattern but a bad parity bit. A design that gates on parity instead of on the pattern would emit a spurious word.
- A chain with twenty kept groups read while the consumer refuses every word. A design that pushes into a full FIFO loses words. A design that keeps clocking the front end during the stall shifts the bit stream out of alignment.
- A second read command during a readout. A design that re-arms would stretch busy and over-clock the chains.
- A fast clear with a word already waiting. A design that leaves the FIFO intact would deliver stale data.

// File: rtl/hwr_pkg.sv
// Package: shared types for the hit-word readout controller.
// Assumes: nothing beyond IEEE 1800-2017.
package hwr_pkg;

    // Phase of the readout sequencer.
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,   // no readout, readout clock held low
        SEQ_HIGH = 2'd1,   // readout clock high for one bit slot
        SEQ_LOW  = 2'd2,   // readout clock low for one bit slot
        SEQ_EMIT = 2'd3    // group complete, store word or wait for space
    } seq_state_t;

    // Width needed to count 0..n-1, at least 1.
    function automatic int cnt_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/hwr_sequencer.sv
// Module: hwr_sequencer
// Walks the chains in ascending order. For each chain it walks the groups,
// and for each group it produces GROUP_WIDTH+1 readout clock pulses.
// After the parity bit it spends one EMIT cycle, in which the group is
// stored and the counters advance. If the group holds a hit and the FIFO
// is full, it stays in EMIT until space frees up.
// Assumes: read_start is a single-cycle pulse. fast_clear has priority
// over every other input.
module hwr_sequencer
    import hwr_pkg::*;
#(
    parameter int NUM_STREAMS       = 4,
    parameter int GROUPS_PER_STREAM = 32,
    parameter int GROUP_WIDTH       = 8,
    parameter int HALF_PERIOD       = 2,
    localparam int BIT_W = cnt_width(GROUP_WIDTH + 1),
    localparam int GRP_W = cnt_width(GROUPS_PER_STREAM),
    localparam int STR_W = cnt_width(NUM_STREAMS),
    localparam int PH_W  = cnt_width(HALF_PERIOD)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             read_start,
    input  logic             fast_clear,
    input  logic             grp_hit,
    input  logic             fifo_full,
    output logic             busy,
    output logic             clk_high,
    output logic             sample_stb,
    output logic             emit,
    output logic [BIT_W-1:0] bit_idx,
    output logic [GRP_W-1:0] grp_idx,
    output logic [STR_W-1:0] str_idx
);

    seq_state_t      state;
    logic [PH_W-1:0] ph_cnt;
    logic            ph_last;
    logic            last_bit;
    logic            last_grp;
    logic            last_str;
    logic            may_leave;

    assign ph_last   = (ph_cnt == PH_W'(HALF_PERIOD - 1));
    assign last_bit  = (bit_idx == BIT_W'(GROUP_WIDTH));
    assign last_grp  = (grp_idx == GRP_W'(GROUPS_PER_STREAM - 1));
    assign last_str  = (str_idx == STR_W'(NUM_STREAMS - 1));
    assign may_leave = !(grp_hit && fifo_full);

    // Decode the strobes that the datapath uses from the current phase.
    always_comb begin
        busy       = (state != SEQ_IDLE);
        clk_high   = (state == SEQ_HIGH);
        sample_stb = (state == SEQ_HIGH) && ph_last;
        emit       = (state == SEQ_EMIT) && grp_hit && !fifo_full;
    end

    // Advance the phase, bit, group and chain counters.
    always_ff @(posedge clk) begin
        if (!rst_n || fast_clear) begin
            state   <= SEQ_IDLE;
            ph_cnt  <= '0;
            bit_idx <= '0;
            grp_idx <= '0;
            str_idx <= '0;
        end else begin
            unique case (state)
                SEQ_IDLE: begin
                    if (read_start) begin
                        state   <= SEQ_HIGH;
                        ph_cnt  <= '0;
                        bit_idx <= '0;
                        grp_idx <= '0;
                        str_idx <= '0;
                    end
                end
                SEQ_HIGH: begin
                    if (ph_last) begin
                        ph_cnt <= '0;
                        state  <= SEQ_LOW;
                    end else begin
                        ph_cnt <= ph_cnt + 1'b1;
                    end
                end
                SEQ_LOW: begin
                    if (ph_last) begin
                        ph_cnt <= '0;
                        if (last_bit) begin
                            state <= SEQ_EMIT;
                        end else begin
                            bit_idx <= bit_idx + 1'b1;
                            state   <= SEQ_HIGH;
                        end
                    end else begin
                        ph_cnt <= ph_cnt + 1'b1;
                    end
                end
                SEQ_EMIT: begin
                    if (may_leave) begin
                        bit_idx <= '0;
                        if (last_grp) begin
                            grp_idx <= '0;
                            if (last_str) begin
                                state <= SEQ_IDLE;
                            end else begin
                                str_idx <= str_idx + 1'b1;
                                state   <= SEQ_HIGH;
                            end
                        end else begin
                            grp_idx <= grp_idx + 1'b1;
                            state   <= SEQ_HIGH;
                        end
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/hwr_group_deser.sv
// Module: hwr_group_deser
// Collects the GROUP_WIDTH wire bits and the parity bit of one group.
// Each sample goes into the slot that the bit index selects, so no
// clearing is needed between groups. Checks odd parity over all bits.
// Assumes: every bit of the group is sampled before the group is used.
module hwr_group_deser
    import hwr_pkg::*;
#(
    parameter int GROUP_WIDTH = 8,
    localparam int BIT_W = cnt_width(GROUP_WIDTH + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sample_stb,
    input  logic [BIT_W-1:0]       bit_idx,
    input  logic                   ser_in,
    output logic [GROUP_WIDTH-1:0] pattern,
    output logic                   par_err,
    output logic                   hit
);

    logic par_bit;

    // Store each sampled wire bit in its slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pattern <= '0;
        end else begin
            for (int i = 0; i < GROUP_WIDTH; i++) begin
                if (sample_stb && (bit_idx == BIT_W'(i))) begin
                    pattern[i] <= ser_in;
                end
            end
        end
    end

    // Store the trailing parity bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            par_bit <= 1'b1;
        end else if (sample_stb && (bit_idx == BIT_W'(GROUP_WIDTH))) begin
            par_bit <= ser_in;
        end
    end

    // Odd parity over the whole group and detection of any hit.
    always_comb begin
        par_err = ~(^{pattern, par_bit});
        hit     = |pattern;
    end

endmodule

// File: rtl/hwr_word_fifo.sv
// Module: hwr_word_fifo
// Circular-buffer FIFO with a first-word-fall-through output and a
// synchronous flush.
// Assumes: the writer never pushes while full.
module hwr_word_fifo
    import hwr_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int DEPTH = 16,
    localparam int PTR_W = cnt_width(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop_ready,
    output logic             out_valid,
    output logic [WIDTH-1:0] dout,
    output logic             full
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] count;
    logic             pop;

    assign out_valid = (count != '0);
    assign full      = (count == CNT_W'(DEPTH));
    assign pop       = out_valid && pop_ready;
    assign dout      = mem[rd_ptr];

    // Next position of a pointer, wrapping at DEPTH.
    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Write storage. It has no reset, because the count guards every read.
    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= din;
        end
    end

    // Maintain the pointers and the fill count.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            unique case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/hwr_trig_pulse.sv
// Module: hwr_trig_pulse
// Stretches a single-cycle kick into a pulse of exactly TRIG_CYCLES
// cycles. The pulse starts on the cycle after the kick.
// Assumes: kicks are further apart than TRIG_CYCLES.
module hwr_trig_pulse #(
    parameter int TRIG_CYCLES = 4,
    localparam int TC_W = $clog2(TRIG_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic kick,
    output logic pulse
);

    logic [TC_W-1:0] remain;

    assign pulse = (remain != '0);

    // Load the pulse length on a kick, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            remain <= '0;
        end else if (kick) begin
            remain <= TC_W'(TRIG_CYCLES);
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

endmodule

// File: rtl/hwr_readout.sv
// Module: hwr_readout (top)
// Zero-suppressing readout of NUM_STREAMS serial chains of latched wire
// bits. It gates one readout clock per chain and deserializes groups of
// GROUP_WIDTH wires plus one parity bit. Empty groups are dropped. Each
// kept group becomes {parity error, block address, pattern}, goes into a
// FIFO and fires one trigger pulse.
// Assumes: the front end changes ro_data only after a falling edge of its
// ro_clk bit. GROUPS_PER_STREAM >= 2.
module hwr_readout
    import hwr_pkg::*;
#(
    parameter int NUM_STREAMS       = 4,
    parameter int GROUPS_PER_STREAM = 32,
    parameter int GROUP_WIDTH       = 8,
    parameter int HALF_PERIOD       = 2,
    parameter int TRIG_CYCLES       = 4,
    parameter int FIFO_DEPTH        = 16,
    localparam int ADDR_W = $clog2(NUM_STREAMS * GROUPS_PER_STREAM),
    localparam int WORD_W = 1 + ADDR_W + GROUP_WIDTH
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   read_start,
    input  logic                   fast_clear,
    output logic [NUM_STREAMS-1:0] ro_clk,
    input  logic [NUM_STREAMS-1:0] ro_data,
    output logic                   busy,
    output logic                   trig_out,
    output logic                   word_valid,
    input  logic                   word_ready,
    output logic [WORD_W-1:0]      word_data
);

    localparam int BIT_W = cnt_width(GROUP_WIDTH + 1);
    localparam int GRP_W = cnt_width(GROUPS_PER_STREAM);
    localparam int STR_W = cnt_width(NUM_STREAMS);

    logic                   clk_high;
    logic                   sample_stb;
    logic                   emit;
    logic [BIT_W-1:0]       bit_idx;
    logic [GRP_W-1:0]       grp_idx;
    logic [STR_W-1:0]       str_idx;
    logic                   ser_bit;
    logic [GROUP_WIDTH-1:0] pattern;
    logic                   par_err;
    logic                   grp_hit;
    logic                   fifo_full;
    logic [ADDR_W-1:0]      blk_addr;
    logic [WORD_W-1:0]      new_word;

    hwr_sequencer #(
        .NUM_STREAMS       (NUM_STREAMS),
        .GROUPS_PER_STREAM (GROUPS_PER_STREAM),
        .GROUP_WIDTH       (GROUP_WIDTH),
        .HALF_PERIOD       (HALF_PERIOD)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .read_start (read_start),
        .fast_clear (fast_clear),
        .grp_hit    (grp_hit),
        .fifo_full  (fifo_full),
        .busy       (busy),
        .clk_high   (clk_high),
        .sample_stb (sample_stb),
        .emit       (emit),
        .bit_idx    (bit_idx),
        .grp_idx    (grp_idx),
        .str_idx    (str_idx)
    );

    // Route the gated clock only to the chain being read.
    for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_clk
        assign ro_clk[s] = clk_high && (str_idx == STR_W'(s));
    end

    // Select the serial input of the chain being read.
    assign ser_bit = ro_data[str_idx];

    hwr_group_deser #(
        .GROUP_WIDTH (GROUP_WIDTH)
    ) u_deser (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_stb (sample_stb),
        .bit_idx    (bit_idx),
        .ser_in     (ser_bit),
        .pattern    (pattern),
        .par_err    (par_err),
        .hit        (grp_hit)
    );

    // Global block address and the packed output word.
    always_comb begin
        blk_addr = ADDR_W'(str_idx) * ADDR_W'(GROUPS_PER_STREAM)
                 + ADDR_W'(grp_idx);
        new_word = {par_err, blk_addr, pattern};
    end

    hwr_word_fifo #(
        .WIDTH (WORD_W),
        .DEPTH (FIFO_DEPTH)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (fast_clear),
        .push      (emit),
        .din       (new_word),
        .pop_ready (word_ready),
        .out_valid (word_valid),
        .dout      (word_data),
        .full      (fifo_full)
    );

    hwr_trig_pulse #(
        .TRIG_CYCLES (TRIG_CYCLES)
    ) u_trig (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (fast_clear),
        .kick  (emit),
        .pulse (trig_out)
    );

endmodule

// File: rtl/hwr_readout_chk.sv
// Module: hwr_readout_chk
// Port-level properties of hwr_readout. The bind statement at the end of
// this file attaches it to every instance of the top module.
// Assumes: synchronous active-low reset.
module hwr_readout_chk #(
    parameter int NUM_STREAMS = 4,
    parameter int WORD_W      = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   read_start,
    input logic                   fast_clear,
    input logic [NUM_STREAMS-1:0] ro_clk,
    input logic                   busy,
    input logic                   trig_out,
    input logic                   word_valid,
    input logic                   word_ready,
    input logic [WORD_W-1:0]      word_data
);

    // R1: no more than one chain is clocked at a time.
    a_r1_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ro_clk));

    // R1: the clock is quiet outside a readout.
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (ro_clk == '0));

    // R8: an accepted read command raises busy.
    a_r8_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && read_start && !fast_clear) |=> busy);

    // R7: a trigger pulse starts only right after readout activity.
    a_r7_trig_in_readout: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trig_out) |-> $past(busy));

    // R10: a fast clear returns every output to idle.
    a_r10_fast_clear: assert property (@(posedge clk) disable iff (!rst_n)
        fast_clear |=> (!busy && (ro_clk == '0) && !word_valid && !trig_out));

    // R12: a refused word is held unchanged.
    a_r12_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && !word_ready && !fast_clear)
            |=> (word_valid && $stable(word_data)));

endmodule

bind hwr_readout hwr_readout_chk #(
    .NUM_STREAMS (NUM_STREAMS),
    .WORD_W      (WORD_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .read_start (read_start),
    .fast_clear (fast_clear),
    .ro_clk     (ro_clk),
    .busy       (busy),
    .trig_out   (trig_out),
    .word_valid (word_valid),
    .word_ready (word_ready),
    .word_data  (word_data)
);

// File: tb/hwr_readout_tb.sv
// Bench for hwr_readout: a table of hit vectors is walked event by event,
// followed by directed tests for a repeated start, a stall and a fast clear.
module hwr_readout_tb;

    localparam int NS    = 4;
    localparam int NG    = 32;
    localparam int GW    = 8;
    localparam int HALF  = 2;
    localparam int TRIG  = 4;
    localparam int DEPTH = 16;
    localparam int PULSES   = NG * (GW + 1);
    localparam int BUSY_LEN = NS * NG * (2 * HALF * (GW + 1) + 1);
    localparam int NUM_EV   = 4;
    localparam int NHITS    = 10;

    // Hit entry: [18:16] event, [15:14] chain, [13:9] group, [8:1] pattern, [0] bad parity.
    localparam logic [18:0] HITS [NHITS] = '{
        {3'd0, 2'd0, 5'd0,  8'h01, 1'b0},
        {3'd0, 2'd3, 5'd31, 8'h80, 1'b0},
        {3'd1, 2'd0, 5'd31, 8'h3C, 1'b0},
        {3'd1, 2'd1, 5'd5,  8'hA5, 1'b1},
        {3'd1, 2'd2, 5'd0,  8'h00, 1'b1},
        {3'd1, 2'd2, 5'd17, 8'hFF, 1'b0},
        {3'd2, 2'd0, 5'd1,  8'h55, 1'b0},
        {3'd2, 2'd0, 5'd2,  8'hAA, 1'b0},
        {3'd2, 2'd3, 5'd0,  8'h01, 1'b1},
        {3'd2, 2'd3, 5'd1,  8'h10, 1'b0}
    };
    // Consumer behaviour per event: 0 always ready, 1 ready every third cycle.
    localparam int EV_MODE [NUM_EV] = '{0, 0, 1, 0};

    logic          clk = 1'b0;
    logic          rst_n;
    logic          read_start;
    logic          fast_clear;
    logic [NS-1:0] ro_clk;
    logic [NS-1:0] ro_data;
    logic          busy;
    logic          trig_out;
    logic          word_valid;
    logic          word_ready = 1'b0;
    logic [15:0]   word_data;

    always #2 clk = ~clk;

    hwr_readout #(
        .NUM_STREAMS (NS), .GROUPS_PER_STREAM (NG), .GROUP_WIDTH (GW),
        .HALF_PERIOD (HALF), .TRIG_CYCLES (TRIG), .FIFO_DEPTH (DEPTH)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .read_start (read_start),
        .fast_clear (fast_clear), .ro_clk (ro_clk), .ro_data (ro_data),
        .busy (busy), .trig_out (trig_out), .word_valid (word_valid),
        .word_ready (word_ready), .word_data (word_data)
    );

    // Front-end model and expected results.
    logic [7:0]  fe_pat [NS][NG];
    logic        fe_bad [NS][NG];
    logic [15:0] exp_w [64];
    int          nexp;

    // Monitor state.
    logic [15:0] got [64];
    int  ngot, fe_idx [NS], pulses [NS];
    logic [NS-1:0] prev_ro;
    int  trig_pulses, trig_len, trig_badw, busy_cyc, idle_viol, multi_viol;
    logic trig_prev;
    int  mode, ncyc;
    logic clr_req = 1'b0;
    int  total = 0, failed = 0;

    // Bit i of a chain: wire bits first, then odd parity (optionally inverted).
    function automatic logic fe_bit(input int s, input int i);
        int g = i / (GW + 1);
        int b = i % (GW + 1);
        if (g >= NG) return 1'b0;
        if (b < GW) return fe_pat[s][g][b];
        return (~^fe_pat[s][g]) ^ fe_bad[s][g];
    endfunction

    always_comb begin
        for (int s = 0; s < NS; s++) ro_data[s] = fe_bit(s, fe_idx[s]);
    end

    // Sampling away from the active edge: consumer, front-end shifting, counters.
    always @(negedge clk) begin
        if (clr_req) begin
            ngot = 0; trig_pulses = 0; trig_len = 0; trig_badw = 0;
            busy_cyc = 0; idle_viol = 0; multi_viol = 0; trig_prev = 1'b0;
            prev_ro = '0; ncyc = 0;
            for (int s = 0; s < NS; s++) begin fe_idx[s] = 0; pulses[s] = 0; end
        end else begin
            ncyc++;
            word_ready = (mode == 0) ? 1'b1 : (mode == 1) ? (ncyc % 3 == 0) : 1'b0;
            if (word_valid && word_ready && ngot < 64) begin
                got[ngot] = word_data; ngot++;
            end
            for (int s = 0; s < NS; s++) begin
                if (prev_ro[s] && !ro_clk[s]) begin fe_idx[s]++; pulses[s]++; end
            end
            prev_ro = ro_clk;
            if (trig_out) begin
                if (!trig_prev) trig_pulses++;
                trig_len++;
            end else if (trig_prev) begin
                if (trig_len != TRIG) trig_badw++;
                trig_len = 0;
            end
            trig_prev = trig_out;
            if (busy) busy_cyc++;
            if (!busy && ro_clk != '0) idle_viol++;
            if ($countones(ro_clk) > 1) multi_viol++;
        end
    end

    int wd_cyc = 0;
    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        wd_cyc++;
        if (wd_cyc > 150000) begin
            failed++; total++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", wd_cyc);
            $display("%0d/%0d checks passed", total - failed, total);
            $finish;
        end
    end

    task automatic check(input logic ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            failed++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic clear_fe();
        for (int s = 0; s < NS; s++)
            for (int g = 0; g < NG; g++) begin fe_pat[s][g] = 8'h00; fe_bad[s][g] = 1'b0; end
        nexp = 0;
    endtask

    task automatic load_event(input int ev);
        clear_fe();
        for (int h = 0; h < NHITS; h++) begin
            if (int'(HITS[h][18:16]) == ev) begin
                fe_pat[HITS[h][15:14]][HITS[h][13:9]] = HITS[h][8:1];
                fe_bad[HITS[h][15:14]][HITS[h][13:9]] = HITS[h][0];
                if (HITS[h][8:1] != 8'h00) begin   // R5: empty groups expected dropped
                    exp_w[nexp] = {HITS[h][0], HITS[h][15:14], HITS[h][13:9], HITS[h][8:1]};
                    nexp++;
                end
            end
        end
    endtask

    task automatic start_readout(input int md);
        mode = md;
        clr_req = 1'b1;
        @(negedge clk); #1;
        clr_req = 1'b0;
        read_start = 1'b1;
        @(negedge clk);
        read_start = 1'b0;
    endtask

    task automatic finish_and_check(input logic timed);
        while (busy) @(negedge clk);
        repeat (30) @(negedge clk);
        for (int s = 0; s < NS; s++)
            check(pulses[s] == PULSES, "R2 clock pulses per chain", pulses[s], PULSES);
        check(idle_viol == 0, "R1 clock while idle", idle_viol, 0);
        check(multi_viol == 0, "R1 two chains clocked", multi_viol, 0);
        check(ngot == nexp, "R5 word count", ngot, nexp);
        for (int i = 0; i < nexp && i < ngot; i++)
            check(got[i] == exp_w[i], "R4 R6 word content/order", got[i], exp_w[i]);
        check(trig_pulses == nexp, "R7 trigger pulse count", trig_pulses, nexp);
        check(trig_badw == 0, "R7 trigger pulse width", trig_badw, 0);
        if (timed) check(busy_cyc == BUSY_LEN, "R8 busy length", busy_cyc, BUSY_LEN);
    endtask

    initial begin
        rst_n = 1'b0; read_start = 1'b0; fast_clear = 1'b0; mode = 0;
        clear_fe();
        clr_req = 1'b1;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        clr_req = 1'b0;
        @(negedge clk);
        // R11: reset state
        check(busy == 1'b0, "R11 busy after reset", busy, 0);
        check(ro_clk == '0, "R11 ro_clk after reset", ro_clk, 0);
        check(word_valid == 1'b0, "R11 word_valid after reset", word_valid, 0);
        check(trig_out == 1'b0, "R11 trig_out after reset", trig_out, 0);

        // Table-driven events (R2 R3 R4 R5 R6 R7 R8)
        for (int ev = 0; ev < NUM_EV; ev++) begin
            load_event(ev);
            start_readout(EV_MODE[ev]);
            finish_and_check(1'b1);
        end

        // R8: a second start during the readout is ignored
        load_event(0);
        start_readout(0);
        repeat (500) @(negedge clk);
        read_start = 1'b1;
        @(negedge clk);
        read_start = 1'b0;
        finish_and_check(1'b1);

        // R9 R12: twenty kept groups against a consumer that refuses every word
        clear_fe();
        for (int g = 0; g < 20; g++) begin
            fe_pat[0][g] = 8'(g + 1);
            exp_w[nexp] = {1'b0, 7'(g), 8'(g + 1)};
            nexp++;
        end
        start_readout(2);
        repeat (1200) @(negedge clk);
        begin
            logic [15:0] w0;
            int p0;
            w0 = word_data; p0 = pulses[0];
            check(ngot == 0, "R9 no word taken while refused", ngot, 0);
            check(busy == 1'b1, "R9 busy during stall", busy, 1);
            check(p0 == 17 * (GW + 1), "R9 clock pulses up to stall", p0, 17 * (GW + 1));
            repeat (300) @(negedge clk);
            check(pulses[0] == p0, "R9 clock paused while full", pulses[0], p0);
            check(ro_clk == '0, "R9 clock low while full", ro_clk, 0);
            check(word_valid == 1'b1, "R12 valid held", word_valid, 1);
            check(word_data == w0, "R12 data held", word_data, w0);
            check(word_data == 16'h0001, "R12 head word", word_data, 16'h0001);
        end
        mode = 0;
        finish_and_check(1'b0);

        // R10: fast clear with a word waiting
        load_event(1);
        start_readout(2);
        repeat (1500) @(negedge clk);
        check(word_valid == 1'b1, "R10 word waiting before clear", word_valid, 1);
        check(busy == 1'b1, "R10 busy before clear", busy, 1);
        fast_clear = 1'b1;
        @(negedge clk);
        fast_clear = 1'b0;
        check(busy == 1'b0, "R10 busy after clear", busy, 0);
        check(ro_clk == '0, "R10 ro_clk after clear", ro_clk, 0);
        check(word_valid == 1'b0, "R10 FIFO emptied", word_valid, 0);
        check(trig_out == 1'b0, "R10 trig after clear", trig_out, 0);
        repeat (50) @(negedge clk);
        check(busy == 1'b0, "R10 stays idle", busy, 0);
        load_event(0);
        start_readout(0);
        finish_and_check(1'b1);   // R10: clean readout after the abort

        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

endmodule